// File: doc/BRIEF.md
# Dual-Core Interrupt Router

This block collects up to 62 level-sensitive interrupt sources and delivers them to two processor cores. Core 0 is the main CPU and core 1 is the coprocessor. A source is active when its input is high or when software has forced it. Each core keeps its own enable mask and its own per-source steering bit. Steering 0 sends an enabled, active source to that core's IRQ line. Steering 1 sends it to the core's FIQ line. Peripherals clear their own requests, so the block has no acknowledge path. It also does no vectoring, nesting or index encoding.

Software reaches the block over a simple 32-bit register bus. A write is a single cycle with `bus_wr` high. A read is combinational from `bus_addr`. Every source vector is split across two words. The low word holds sources 0–29 in bits 0–29. The high word holds sources 30 and up in bits 0–31, with source 30+k in bit k. Address bit 2 selects the high word, and address bits 1:0 are ignored.

The global words are:
- Active at 0x00/0x04 (read only).
- Forced at 0x08/0x0C (read only).
- Force-set at 0x10/0x14 (write only, reads 0).
- Force-clear at 0x18/0x1C (write only, reads 0).

Each core has a window. Core 0 starts at 0x80 and core 1 starts at 0xC0. Inside the window the words are:
- Pending at +0x00/+0x04.
- IRQ status at +0x08/+0x0C.
- FIQ status at +0x10/+0x14.
- Enable mask at +0x18/+0x1C.
- Enable-set at +0x20/+0x24 (write only).
- Enable-clear at +0x28/+0x2C (write only).
- Steering at +0x30/+0x34 (read/write).

Top module: `dual_irq_router`

## Requirements
- R1: After reset, the forced bits, both enable masks and both steering vectors read 0, and `irq_o` and `fiq_o` are 0.
- R2: The Active words (0x00 low, 0x04 high) read `src OR forced`. Low-word bits 30 and 31 read 0.
- R3: Writing 0x10/0x14 sets the forced bits written as 1. Writing 0x18/0x1C clears them. Bits written as 0 stay unchanged. The Forced words read back at 0x08/0x0C, and the set and clear words read 0.
- R4: Writing a core's enable-set word (+0x20/+0x24) enables the sources written as 1. Writing its enable-clear word (+0x28/+0x2C) disables them. Other bits stay unchanged, and the mask reads back at +0x18/+0x1C.
- R5: A core's steering word (+0x30/+0x34) is read/write. A bit of 0 routes that source to IRQ and a bit of 1 routes it to FIQ. A write replaces only the 30 or 32 bits of the addressed half.
- R6: A core's pending word reads `active AND mask`. Bit 30 of the low pending word reads 1 when any high-bank source is pending for that core.
- R7: A core's IRQ status word reads `pending AND NOT steering`. Its FIQ status word reads `pending AND steering`.
- R8: Each output is registered. `irq_o[c]` equals, one clock late, the OR of core c's pending bits with steering 0, and `fiq_o[c]` equals the same with steering 1. So a change to a source, a forced bit, a mask or a steering bit reaches the outputs one clock after it takes effect.
- R9: The two cores are independent. A write to one core's mask or steering never changes the other core's state or outputs.
- R10: Several stimuli are ignored or combined:
  - Bits 30–31 of a low-word write are ignored.
  - Writes to unmapped or read-only addresses change nothing.
  - A register write and a source change in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | NUM_SRC | Level interrupt sources, synchronous to clk |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 2 | IRQ line per core (bit 0 CPU, bit 1 coprocessor) |
| fiq_o | output | 2 | FIQ line per core (bit 0 CPU, bit 1 coprocessor) |

## Verification
The block holds only forced bits, two masks and two steering vectors, so any corrupted bit is visible to software. A bad bit changes a readback word in the same cycle it is read. If the source is active, the bad bit also flips an IRQ or FIQ line one clock later. A line steered to the wrong output shows up as IRQ and FIQ swapped on the next edge. A missing cascade summary appears only in bit 30 of a low pending word, and only while a high-bank source is pending. Comparing every output on every clock against a behavioural model catches these faults within one cycle of the stimulus that exposes them.

// File: rtl/dir_pkg.sv
package dir_pkg;
    localparam int LO_N        = 30;
    localparam int CASCADE_BIT = 30;
    localparam int ADDR_W      = 8;
    localparam int NCORE       = 2;

    typedef enum logic [1:0] {
        G_ACTIVE = 2'd0,
        G_FORCE  = 2'd1,
        G_FSET   = 2'd2,
        G_FCLR   = 2'd3
    } glob_reg_e;

    typedef enum logic [2:0] {
        C_PEND  = 3'd0,
        C_IRQ   = 3'd1,
        C_FIQ   = 3'd2,
        C_EN    = 3'd3,
        C_ENSET = 3'd4,
        C_ENCLR = 3'd5,
        C_STEER = 3'd6,
        C_NONE  = 3'd7
    } core_reg_e;

    // Select the low or high 32-bit view of a source vector
    function automatic logic [31:0] pick_word(input logic [63:0] vec, input logic hi);
        if (hi) begin
            return vec[LO_N+31:LO_N];
        end
        return {2'b00, vec[LO_N-1:0]};
    endfunction
endpackage

// File: rtl/dir_bus_decode.sv
module dir_bus_decode
    import dir_pkg::*;
#(
    parameter int NUM_SRC = 62
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [NUM_SRC-1:0] lane,
    output logic [NUM_SRC-1:0] wbits,
    output logic               frc_set,
    output logic               frc_clr,
    output logic [NCORE-1:0]   en_set,
    output logic [NCORE-1:0]   en_clr,
    output logic [NCORE-1:0]   steer_wr,
    output logic               glob_ok,
    output logic               core_ok,
    output logic               core_id,
    output logic               hi,
    output glob_reg_e          gsel,
    output core_reg_e          csel
);
    logic unused_lsb;

    assign unused_lsb = ^bus_addr[1:0];
    assign hi         = bus_addr[2];
    assign gsel       = glob_reg_e'(bus_addr[4:3]);
    assign csel       = core_reg_e'(bus_addr[5:3]);
    assign core_id    = bus_addr[6];
    assign glob_ok    = !bus_addr[7] && (bus_addr[6:5] == 2'b00);
    assign core_ok    = bus_addr[7] && (csel != C_NONE);

    // Map the 32-bit write word onto the source lanes of the addressed half
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        if (i < LO_N) begin : g_lo
            assign lane[i]  = !hi;
            assign wbits[i] = !hi && bus_wdata[i];
        end else begin : g_hi
            assign lane[i]  = hi;
            assign wbits[i] = hi && bus_wdata[i-LO_N];
        end
    end

    always_comb begin
        frc_set = bus_wr && glob_ok && (gsel == G_FSET);
        frc_clr = bus_wr && glob_ok && (gsel == G_FCLR);
        for (int c = 0; c < NCORE; c++) begin
            en_set[c]   = bus_wr && core_ok && (core_id == 1'(c)) && (csel == C_ENSET);
            en_clr[c]   = bus_wr && core_ok && (core_id == 1'(c)) && (csel == C_ENCLR);
            steer_wr[c] = bus_wr && core_ok && (core_id == 1'(c)) && (csel == C_STEER);
        end
    end
endmodule

// File: rtl/dir_force_bank.sv
module dir_force_bank #(
    parameter int NUM_SRC = 62
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frc_set,
    input  logic               frc_clr,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] force_q
);
    typedef struct packed {
        logic [NUM_SRC-1:0] frc;
    } frc_st_t;

    frc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frc_set) begin
            st_d.frc = st_q.frc | wbits;
        end
        if (frc_clr) begin
            st_d.frc = st_q.frc & ~wbits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign force_q = st_q.frc;
endmodule

// File: rtl/dir_core_path.sv
module dir_core_path #(
    parameter int NUM_SRC = 62
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] active,
    input  logic [NUM_SRC-1:0] lane,
    input  logic [NUM_SRC-1:0] wbits,
    input  logic               en_set,
    input  logic               en_clr,
    input  logic               steer_wr,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] steer_q,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] irq_stat,
    output logic [NUM_SRC-1:0] fiq_stat,
    output logic               irq_o,
    output logic               fiq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] steer;
        logic               irq;
        logic               fiq;
    } core_st_t;

    core_st_t st_d, st_q;

    assign pend     = active & st_q.en;
    assign irq_stat = pend & ~st_q.steer;
    assign fiq_stat = pend & st_q.steer;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |irq_stat;
        st_d.fiq = |fiq_stat;
        if (en_set) begin
            st_d.en = st_q.en | wbits;
        end
        if (en_clr) begin
            st_d.en = st_q.en & ~wbits;
        end
        if (steer_wr) begin
            st_d.steer = (st_q.steer & ~lane) | wbits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q    = st_q.en;
    assign steer_q = st_q.steer;
    assign irq_o   = st_q.irq;
    assign fiq_o   = st_q.fiq;
endmodule

// File: rtl/dual_irq_router.sv
module dual_irq_router
    import dir_pkg::*;
#(
    parameter int NUM_SRC = 62
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NCORE-1:0]   irq_o,
    output logic [NCORE-1:0]   fiq_o
);
    logic [NUM_SRC-1:0] lane;
    logic [NUM_SRC-1:0] wbits;
    logic               frc_set;
    logic               frc_clr;
    logic [NCORE-1:0]   en_set;
    logic [NCORE-1:0]   en_clr;
    logic [NCORE-1:0]   steer_wr;
    logic               glob_ok;
    logic               core_ok;
    logic               core_id;
    logic               hi;
    glob_reg_e          gsel;
    core_reg_e          csel;

    logic [NUM_SRC-1:0] force_q;
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] en_q     [NCORE];
    logic [NUM_SRC-1:0] steer_q  [NCORE];
    logic [NUM_SRC-1:0] pend     [NCORE];
    logic [NUM_SRC-1:0] irq_stat [NCORE];
    logic [NUM_SRC-1:0] fiq_stat [NCORE];

    dir_bus_decode #(.NUM_SRC(NUM_SRC)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .lane     (lane),
        .wbits    (wbits),
        .frc_set  (frc_set),
        .frc_clr  (frc_clr),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .steer_wr (steer_wr),
        .glob_ok  (glob_ok),
        .core_ok  (core_ok),
        .core_id  (core_id),
        .hi       (hi),
        .gsel     (gsel),
        .csel     (csel)
    );

    dir_force_bank #(.NUM_SRC(NUM_SRC)) u_frc (
        .clk    (clk),
        .rst_n  (rst_n),
        .frc_set(frc_set),
        .frc_clr(frc_clr),
        .wbits  (wbits),
        .force_q(force_q)
    );

    assign active = src | force_q;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        dir_core_path #(.NUM_SRC(NUM_SRC)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (active),
            .lane    (lane),
            .wbits   (wbits),
            .en_set  (en_set[c]),
            .en_clr  (en_clr[c]),
            .steer_wr(steer_wr[c]),
            .en_q    (en_q[c]),
            .steer_q (steer_q[c]),
            .pend    (pend[c]),
            .irq_stat(irq_stat[c]),
            .fiq_stat(fiq_stat[c]),
            .irq_o   (irq_o[c]),
            .fiq_o   (fiq_o[c])
        );
    end

    logic [63:0] sel_vec;
    logic        cascade_on;

    always_comb begin
        sel_vec    = '0;
        cascade_on = 1'b0;
        if (glob_ok) begin
            case (gsel)
                G_ACTIVE: sel_vec = 64'(active);
                G_FORCE:  sel_vec = 64'(force_q);
                default:  sel_vec = '0;
            endcase
        end else if (core_ok) begin
            case (csel)
                C_PEND: begin
                    sel_vec    = 64'(pend[core_id]);
                    cascade_on = !hi;
                end
                C_IRQ:   sel_vec = 64'(irq_stat[core_id]);
                C_FIQ:   sel_vec = 64'(fiq_stat[core_id]);
                C_EN:    sel_vec = 64'(en_q[core_id]);
                C_STEER: sel_vec = 64'(steer_q[core_id]);
                default: sel_vec = '0;
            endcase
        end
        bus_rdata = pick_word(sel_vec, hi);
        if (cascade_on) begin
            bus_rdata[CASCADE_BIT] = |pend[core_id][NUM_SRC-1:LO_N];
        end
    end
endmodule

// File: rtl/dual_irq_router_chk.sv
module dual_irq_router_chk
    import dir_pkg::*;
#(
    parameter int NUM_SRC = 62
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NCORE-1:0]   irq_o,
    input logic [NCORE-1:0]   fiq_o,
    input logic [NUM_SRC-1:0] force_q,
    input logic [NUM_SRC-1:0] en_cpu,
    input logic [NUM_SRC-1:0] en_cop,
    input logic [NUM_SRC-1:0] steer_cpu,
    input logic [NUM_SRC-1:0] steer_cop
);
    localparam int HI_N = NUM_SRC - LO_N;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_o == '0 && fiq_o == '0));

    // R8
    cpu_irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] == $past(|((src | force_q) & en_cpu & ~steer_cpu)));

    // R8
    cop_fiq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o[1] == $past(|((src | force_q) & en_cop & steer_cop)));

    // R3
    frc_clear_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h18) |=>
            ((force_q[LO_N-1:0] & $past(bus_wdata[LO_N-1:0])) == '0));

    // R4
    cpu_en_set_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'hA4) |=>
            ((en_cpu[NUM_SRC-1:LO_N] & $past(bus_wdata[HI_N-1:0])) == $past(bus_wdata[HI_N-1:0])));

    // R10
    lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[2]) |=>
            ($stable(force_q[NUM_SRC-1:LO_N]) && $stable(en_cpu[NUM_SRC-1:LO_N]) &&
             $stable(en_cop[NUM_SRC-1:LO_N]) && $stable(steer_cpu[NUM_SRC-1:LO_N]) &&
             $stable(steer_cop[NUM_SRC-1:LO_N])));

    // R6
    cascade_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h80) |->
            (bus_rdata[CASCADE_BIT] == |((src[NUM_SRC-1:LO_N] | force_q[NUM_SRC-1:LO_N]) & en_cpu[NUM_SRC-1:LO_N])));
endmodule

bind dual_irq_router dual_irq_router_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o),
    .force_q  (force_q),
    .en_cpu   (en_q[0]),
    .en_cop   (en_q[1]),
    .steer_cpu(steer_q[0]),
    .steer_cop(steer_q[1])
);

// File: tb/dual_irq_router_test.sv
module dual_irq_router_test;
    localparam int N = 62;
    localparam logic [63:0] MASK   = (64'd1 << N) - 64'd1;
    localparam logic [63:0] LOMASK = 64'h0000_0000_3FFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic [7:0]    addr = '0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [1:0]    irq_o;
    logic [1:0]    fiq_o;

    int tests = 0;
    int fails = 0;

    dual_irq_router #(.NUM_SRC(N)) uut (
        .clk(clk), .rst_n(rst_n), .src(src), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #5 clk = ~clk;

    // Behavioural reference state
    logic [63:0] m_frc = '0;
    logic [63:0] m_en [2] = '{default: '0};
    logic [63:0] m_st [2] = '{default: '0};
    logic [1:0]  e_irq = '0;
    logic [1:0]  e_fiq = '0;

    function automatic logic [63:0] m_act();
        return (64'(src) | m_frc) & MASK;
    endfunction

    function automatic logic [31:0] mread(input logic [7:0] a);
        logic [7:0]  key;
        logic [63:0] v;
        logic [63:0] pnd;
        logic [31:0] r;
        int          c;
        key = {a[7:3], 3'b000};
        c   = a[6] ? 1 : 0;
        pnd = m_act() & m_en[c];
        case (key)
            8'h00:        v = m_act();
            8'h08:        v = m_frc;
            8'h80, 8'hC0: v = pnd;
            8'h88, 8'hC8: v = pnd & ~m_st[c];
            8'h90, 8'hD0: v = pnd & m_st[c];
            8'h98, 8'hD8: v = m_en[c];
            8'hB0, 8'hF0: v = m_st[c];
            default:      v = '0;
        endcase
        r = a[2] ? v[61:30] : {2'b00, v[29:0]};
        if ((key == 8'h80 || key == 8'hC0) && !a[2]) begin
            r[30] = |(pnd >> 30);
        end
        return r;
    endfunction

    task automatic mwrite(input logic [7:0] a, input logic [31:0] d);
        logic [63:0] w;
        logic [63:0] ln;
        w  = a[2] ? ((64'(d) << 30) & MASK) : (64'(d) & LOMASK);
        ln = a[2] ? (MASK & ~LOMASK) : LOMASK;
        case ({a[7:3], 3'b000})
            8'h10: m_frc = m_frc | w;
            8'h18: m_frc = m_frc & ~w;
            8'hA0: m_en[0] = m_en[0] | w;
            8'hE0: m_en[1] = m_en[1] | w;
            8'hA8: m_en[0] = m_en[0] & ~w;
            8'hE8: m_en[1] = m_en[1] & ~w;
            8'hB0: m_st[0] = (m_st[0] & ~ln) | w;
            8'hF0: m_st[1] = (m_st[1] & ~ln) | w;
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_frc = '0;
            m_en  = '{default: '0};
            m_st  = '{default: '0};
            e_irq = '0;
            e_fiq = '0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                e_irq[c] = |(m_act() & m_en[c] & ~m_st[c]);
                e_fiq[c] = |(m_act() & m_en[c] & m_st[c]);
            end
            if (wr) mwrite(addr, wdata);
        end
    end

    // R8 R9: every-cycle output comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (irq_o !== e_irq || fiq_o !== e_fiq) begin
                fails++;
                $display("FAIL R8/R9 t=%0t irq=%b fiq=%b expected irq=%b fiq=%b",
                         $time, irq_o, fiq_o, e_irq, e_fiq);
            end
        end
    end

    task automatic rd_chk(input logic [7:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        addr = a;
        wr   = 1'b0;
        #1;
        exp = mread(a);
        tests++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s read 0x%02h got 0x%08h expected 0x%08h", tag, a, rdata, exp);
        end
    endtask

    task automatic wr_op(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic wr_src(input logic [7:0] a, input logic [31:0] d, input logic [N-1:0] s);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        src   = s;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic set_src(input logic [N-1:0] s);
        @(negedge clk);
        src = s;
    endtask

    task automatic out_chk(input logic [1:0] ei, input logic [1:0] ef, input string tag);
        repeat (2) @(negedge clk);
        #1;
        tests++;
        if (irq_o !== ei || fiq_o !== ef) begin
            fails++;
            $display("FAIL %s irq=%b fiq=%b expected irq=%b fiq=%b", tag, irq_o, fiq_o, ei, ef);
        end
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    localparam logic [7:0] WADDR [20] = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'hA0, 8'hA4, 8'hA8,
        8'hAC, 8'hB0, 8'hB4, 8'hE0, 8'hE4, 8'hE8, 8'hEC, 8'hF0, 8'hF4, 8'h40, 8'hB8,
        8'h00, 8'h98};
    localparam logic [7:0] RADDR [16] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h80, 8'h84, 8'h88,
        8'h8C, 8'h90, 8'h94, 8'hC0, 8'hC4, 8'hD0, 8'hD4, 8'hD8, 8'hF4};

    initial begin
        logic [N-1:0] s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        out_chk(2'b00, 2'b00, "R1");
        rd_chk(8'h08, "R1"); rd_chk(8'h0C, "R1");
        rd_chk(8'h98, "R1"); rd_chk(8'hDC, "R1");
        rd_chk(8'hB0, "R1"); rd_chk(8'hF4, "R1");

        // R2: active readback, nothing enabled yet
        s = '0; s[3] = 1'b1; s[40] = 1'b1;
        set_src(s);
        rd_chk(8'h00, "R2"); rd_chk(8'h04, "R2");
        out_chk(2'b00, 2'b00, "R2");

        // R3, R10: forced bits, ignored upper bits of a low write
        wr_op(8'h10, 32'hC000_0005);
        rd_chk(8'h08, "R3"); rd_chk(8'h0C, "R10");
        wr_op(8'h14, 32'h0000_0004);
        rd_chk(8'h0C, "R3");
        wr_op(8'h18, 32'h0000_0001);
        rd_chk(8'h08, "R3"); rd_chk(8'h10, "R3"); rd_chk(8'h00, "R2");

        // R4, R5: CPU enable and steering
        wr_op(8'hA0, 32'h0000_0008);
        out_chk(2'b01, 2'b00, "R4");
        rd_chk(8'h98, "R4");
        wr_op(8'hB0, 32'h0000_0008);
        out_chk(2'b00, 2'b01, "R5");
        rd_chk(8'hB0, "R5");

        // R9: COP enabled for source 40 on IRQ, CPU unchanged
        wr_op(8'hE4, 32'h0000_0400);
        out_chk(2'b10, 2'b01, "R9");
        rd_chk(8'h9C, "R9");

        // R6, R7: pending with cascade, status words
        rd_chk(8'hC0, "R6"); rd_chk(8'hC4, "R6"); rd_chk(8'h80, "R6");
        rd_chk(8'h90, "R7"); rd_chk(8'h88, "R7"); rd_chk(8'hC8, "R7"); rd_chk(8'hCC, "R7");

        // R4: clear CPU enable
        wr_op(8'hA8, 32'h0000_0008);
        out_chk(2'b10, 2'b00, "R4");

        // R10: write and source change in the same cycle
        s = '0; s[5] = 1'b1; s[40] = 1'b1;
        wr_src(8'hA0, 32'h0000_0020, s);
        rd_chk(8'h80, "R10");
        out_chk(2'b11, 2'b00, "R10");

        // R10: unmapped and read-only writes
        wr_op(8'h40, 32'hFFFF_FFFF);
        wr_op(8'h98, 32'hFFFF_FFFF);
        rd_chk(8'h98, "R10"); rd_chk(8'hD8, "R10"); rd_chk(8'h08, "R10");

        // Mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 2);
            if (op == 0) begin
                s = N'({$urandom, $urandom} & ({$urandom, $urandom} | {$urandom, $urandom}));
                set_src(s);
            end else if (op == 1) begin
                wr_op(WADDR[$urandom_range(0, 19)], $urandom & $urandom);
            end else begin
                rd_chk(RADDR[$urandom_range(0, 15)], "R6");
            end
        end

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule